// File: doc/BRIEF.md
# Ramp-Compare Four-Channel ADC Controller

This block is the digital half of a single-slope converter. A free-running counter sets the ramp period. The same counter drives a pulse-width output, and an external RC filter turns that output into a repeating voltage ramp. Four external comparators each compare the ramp with one monitored voltage, such as a supply rail, a loop control voltage or a volume setting. The block watches the four comparator outputs at the same time. For each channel it records the counter value at the first change of the comparator output in a ramp period. That counter value is the channel's binary code.

At the end of every ramp period, the block copies all four codes into the result registers at once and raises a one-cycle valid strobe. A channel whose comparator does not change during the period reports full scale, and its overrange flag is set. Software or a neighbouring block sets the length of the charge phase, so the ramp slope can be matched to the filter.

Top module: `ramp_adc`

## Requirements
- R1: The counter runs through 2^CNT_W states and wraps. `valid_o` is high for exactly one cycle per period, in the cycle that follows the wrap, and stays low in every other cycle.
- R2: `ramp_pwm` is low while the counter is 0, high for counter values 1 through `charge_end`, and low for the rest of the period.
- R3: A comparator change is first sampled at the rising edge that ends counter value c. When c+2 is at most full scale, that change gives code c+2 for its channel in the next result, and that channel's overrange bit is 0. The latency of two is caused by the two-flop synchroniser.
- R4: Both rising and falling changes count. Only the first change in a period is recorded, and later changes in the same period leave the code unchanged.
- R5: A channel with no change detected in a period reports code all ones and sets its `ovr_o` bit to 1. A change detected in the final count (c+2 equal to full scale) reports all ones with `ovr_o` at 0. A change detected in the first cycle of the next period is recorded in that period as code 0.
- R6: Channels are independent. All four codes and flags update together on the strobe and hold their values between strobes. Channel i occupies `code_o[i*CNT_W +: CNT_W]` and `ovr_o[i]`.
- R7: While `rst` is high at a rising edge, the counter, the captured values, the codes, the flags and the strobe are cleared. The counter restarts at 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| charge_end | input | CNT_W | Last counter value with the ramp drive high |
| cmp_in | input | NCH | Comparator outputs, asynchronous |
| ramp_pwm | output | 1 | Ramp drive to the external filter |
| code_o | output | NCH*CNT_W | Per-channel codes, channel 0 in the low bits |
| ovr_o | output | NCH | Per-channel overrange flags |
| valid_o | output | 1 | One-cycle strobe for new results |

## Verification
The bench builds the block with CNT_W=6 and four channels, which gives a 64-cycle period. Short periods let many whole conversions run quickly. The period is also short enough that the bench can reach the last counts of a period directly, where a late change becomes full scale without overrange, or moves into the next period as code 0. A charge end of 40 places both edges of the drive pulse well inside the period, so the high-count check can detect a shifted edge.

// File: rtl/ramp_adc.sv
module ramp_adc #(
  parameter int CNT_W = 8,
  parameter int NCH   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     charge_end,
  input  logic [NCH-1:0]       cmp_in,
  output logic                 ramp_pwm,
  output logic [NCH*CNT_W-1:0] code_o,
  output logic [NCH-1:0]       ovr_o,
  output logic                 valid_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0]            cnt;
  logic [NCH-1:0]              s1, s2, prev, got;
  logic [NCH-1:0][CNT_W-1:0]   lat, cde;
  logic                        last;
  logic [NCH-1:0]              chg;

  assign last     = (cnt == FULL);
  assign chg      = s2 ^ prev;
  assign ramp_pwm = (cnt != '0) && (cnt <= charge_end);
  assign code_o   = cde;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      s1      <= '0;
      s2      <= '0;
      prev    <= '0;
      valid_o <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      s1      <= cmp_in;
      s2      <= s1;
      prev    <= s2;
      valid_o <= last;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        got[i]   <= 1'b0;
        lat[i]   <= '0;
        cde[i]   <= '0;
        ovr_o[i] <= 1'b0;
      end else if (last) begin
        cde[i]   <= got[i] ? lat[i] : FULL;
        ovr_o[i] <= !got[i] && !chg[i];
        got[i]   <= 1'b0;
      end else if (chg[i] && !got[i]) begin
        lat[i] <= cnt;
        got[i] <= 1'b1;
      end
    end
  end
endmodule

module ramp_adc_chk #(
  parameter int CNT_W = 8,
  parameter int NCH   = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [CNT_W-1:0]          cnt,
  input logic [NCH-1:0]            got,
  input logic [NCH-1:0][CNT_W-1:0] lat,
  input logic                      ramp_pwm,
  input logic [NCH*CNT_W-1:0]      code_o,
  input logic [NCH-1:0]            ovr_o,
  input logic                      valid_o
);
  p_single_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  p_strobe_at_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> cnt == '0);
  p_drive_low_at_start_r2: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !ramp_pwm);
  p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(code_o) && $stable(ovr_o)));
  p_reset_clears_r7: assert property (@(posedge clk)
    rst |=> (!valid_o && ovr_o == '0 && code_o == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_first_only_r4: assert property (@(posedge clk) disable iff (rst)
      got[i] |=> $stable(lat[i]));
    p_ovr_full_r5: assert property (@(posedge clk) disable iff (rst)
      (valid_o && ovr_o[i]) |-> (code_o[i*CNT_W +: CNT_W] == '1));
  end
endmodule

bind ramp_adc ramp_adc_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .got(got), .lat(lat),
  .ramp_pwm(ramp_pwm), .code_o(code_o), .ovr_o(ovr_o), .valid_o(valid_o)
);

// File: tb/ramp_adc_tb.sv
module ramp_adc_tb;
  localparam int W   = 6;
  localparam int N   = 4;
  localparam int MAX = (1 << W) - 1;
  localparam int CE  = 40;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [W-1:0]   charge_end = W'(CE);
  logic [N-1:0]   cmp_in = '0;
  logic           ramp_pwm;
  logic [N*W-1:0] code_o;
  logic [N-1:0]   ovr_o;
  logic           valid_o;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ramp_adc #(.CNT_W(W), .NCH(N)) u_dut (
    .clk(clk), .rst(rst), .charge_end(charge_end), .cmp_in(cmp_in),
    .ramp_pwm(ramp_pwm), .code_o(code_o), .ovr_o(ovr_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int k = 0; k < 4 * (MAX + 1); k++) begin
      @(negedge clk);
      if (valid_o) return;
    end
    chk(0, "R1 no strobe", 0, 1);
  endtask

  // At a strobe negedge (counter 0). t1/t2: counter values at which to flip each channel, -1 none.
  task automatic run_cycle(input int t1[N], input int t2[N], output int pw_hi, output bit moved);
    logic [N*W-1:0] c0;
    c0 = code_o;
    moved = 0;
    pw_hi = 0;
    for (int j = 0; j <= MAX; j++) begin
      if (j > 0 && (valid_o || code_o != c0)) moved = 1;
      if (ramp_pwm) pw_hi++;
      for (int i = 0; i < N; i++)
        if (t1[i] == j || t2[i] == j) cmp_in[i] = ~cmp_in[i];
      @(negedge clk);
    end
    chk(valid_o === 1'b1, "R1 strobe after period", int'(valid_o), 1);
  endtask

  task automatic expect_ch(input int i, input int code, input bit ov, input string req);
    chk(int'(code_o[i*W +: W]) == code, req, int'(code_o[i*W +: W]), code);
    chk(ovr_o[i] == ov, {req, " ovr"}, int'(ovr_o[i]), int'(ov));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid_o == 0, "R7 valid", int'(valid_o), 0);
    chk(code_o == '0, "R7 code", int'(code_o), 0);
    chk(ovr_o == '0, "R7 ovr", int'(ovr_o), 0);
    chk(ramp_pwm == 0, "R7 counter at zero", int'(ramp_pwm), 0);
    rst = 1'b0;
    wait_valid();
  endtask

  task automatic t_pwm();
    int hi; bit mv;
    int n1[N] = '{-1, -1, -1, -1};
    chk(ramp_pwm == 0, "R2 low at zero", int'(ramp_pwm), 0);
    run_cycle(n1, n1, hi, mv);
    chk(hi == CE, "R2 high count", hi, CE);
    chk(!mv, "R1 R6 no strobe mid-period", int'(mv), 0);
    for (int i = 0; i < N; i++) expect_ch(i, MAX, 1, "R5 no change");
  endtask

  task automatic t_codes();
    int hi; bit mv;
    int a[N] = '{3, 17, 30, 50};
    int n1[N] = '{-1, -1, -1, -1};
    run_cycle(a, n1, hi, mv);
    for (int i = 0; i < N; i++) expect_ch(i, a[i] + 2, 0, "R3 R6 rising code");
    run_cycle(a, n1, hi, mv);
    for (int i = 0; i < N; i++) expect_ch(i, a[i] + 2, 0, "R4 falling code");
  endtask

  task automatic t_first_only();
    int hi; bit mv;
    int a[N] = '{5, 0, 20, 40};
    int b[N] = '{9, 4, 22, 60};
    run_cycle(a, b, hi, mv);
    for (int i = 0; i < N; i++) expect_ch(i, a[i] + 2, 0, "R4 later change ignored");
  endtask

  task automatic t_edges();
    int hi; bit mv;
    int a[N] = '{MAX - 2, MAX - 1, -1, 10};
    int n1[N] = '{-1, -1, -1, -1};
    run_cycle(a, n1, hi, mv);
    expect_ch(0, MAX, 0, "R5 last-count change");
    expect_ch(1, MAX, 1, "R5 spill change overrange");
    expect_ch(2, MAX, 1, "R5 idle channel");
    expect_ch(3, 12, 0, "R3 code");
    run_cycle(n1, n1, hi, mv);
    expect_ch(1, 0, 0, "R5 spill into next period");
    expect_ch(0, MAX, 1, "R5 idle after change");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pwm();
    t_codes();
    t_first_only();
    t_edges();
    cmp_in = '0;
    repeat (4) @(negedge clk);
    t_reset();
    t_codes();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule